// File: doc/BRIEF.md
# I2C Master Bit Engine

This block drives the clock and data wires of an I2C bus on behalf of a higher-level sequencer. It does not handle messages or addresses. The sequencer hands it one bus primitive at a time: start, repeated start, stop, byte write, byte read, or a master acknowledge bit. The engine then produces the matching open-drain waveform. Each primitive ends with a one-cycle completion pulse. With that pulse the engine reports the acknowledge bit it sampled, the byte it read, or a timeout error.

Timing comes from one programmable period `delayCycles` (D, in clock cycles). The short step between edges is ceil(D/2) cycles. The bus-free gap after a stop and the low phase after each read bit are D cycles. Whenever the engine lets go of SCL, it does not assume the line has risen. It watches the synchronized SCL input until the line reads high, so a target can stretch the clock. If the line stays low for `timeoutCycles` cycles, the primitive is abandoned and flagged.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both line outputs are 1 (released), `busy` is 0, `cmdReady` is 1 and `done` is 0.
- R2: A command is taken when `cmdValid` and `cmdReady` are both 1. From the next cycle `busy` stays 1 until the cycle in which `done` pulses for one cycle with `busy` 0. Opcode values 6 and 7 take no action: `done` pulses in the cycle after acceptance and neither line moves.
- R3: Opcode 0 (start) pulls SDA low while SCL is high. At least ceil(D/2) cycles later it pulls SCL low.
- R4: Opcode 1 (repeated start) releases SDA, then releases SCL and waits for it to read high. It then pulls SDA low while SCL is high and afterwards pulls SCL low, with no stop condition appearing on the bus.
- R5: Opcode 2 (stop) pulls SDA low, releases SCL, and then releases SDA while SCL is high. `done` comes no sooner than D cycles after SDA rises.
- R6: Opcode 3 (write) sends `wrData` MSB first, one bit per SCL high phase. SDA changes only while SCL is low, and the two line outputs never change on the same clock edge.
- R7: At the end of a write, SDA is released for a ninth clock. `ackRx` reports 1 if SDA read low during that clock and 0 if it read high.
- R8: Opcode 4 (read) keeps SDA released and samples 8 bits MSB first, one per SCL high phase. The result appears on `rdData` when `done` pulses. After each bit, SCL is held low for D cycles.
- R9: Opcode 5 (acknowledge) clocks one bit. With `cmdAck` = 1, SDA is held low for that clock. With `cmdAck` = 0, SDA stays released.
- R10: While a target holds SCL low after the engine releases it, the engine waits without advancing the bit, sampling data or finishing the command.
- R11: If SCL has not read high `timeoutCycles` cycles after being released, the command ends with `done` and `timeoutErr` = 1. `timeoutErr` clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Engine idle, command can be taken |
| cmdOp | input | 3 | Opcode: 0 start, 1 repeated start, 2 stop, 3 write, 4 read, 5 acknowledge |
| cmdAck | input | 1 | For opcode 5: 1 sends ACK, 0 sends NACK |
| wrData | input | 8 | Byte for opcode 3 |
| delayCycles | input | DLY_W | Nominal period D in cycles |
| timeoutCycles | input | TMO_W | SCL rise limit in cycles |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte sampled by opcode 4 |
| ackRx | output | 1 | 1 when the target acknowledged the last write |
| timeoutErr | output | 1 | Last command ended on SCL timeout |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sclIn | input | 1 | SCL line level |
| sdaOut | output | 1 | SDA drive: 0 pulls low, 1 releases |
| sdaIn | input | 1 | SDA line level |

## Verification
A sequencer state that skips a step or runs a step twice shows up on the bus within one bit period. The bench's open-drain target model then records a misplaced start or stop edge, a shifted or truncated bit pattern, or an SDA change during SCL high. A wrong shift-register or bit-counter state appears as a wrong `rdData` or a wrong sampled bit pattern at the `done` pulse. A broken rise-wait or timeout counter appears as early progress during a stretch, or as a missing or spurious `timeoutErr` that clears at the wrong time.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  localparam logic [2:0] OP_START   = 3'd0;
  localparam logic [2:0] OP_RESTART = 3'd1;
  localparam logic [2:0] OP_STOP    = 3'd2;
  localparam logic [2:0] OP_WRITE   = 3'd3;
  localparam logic [2:0] OP_READ    = 3'd4;
  localparam logic [2:0] OP_ACK     = 3'd5;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic sclPull;
    logic sclRel;
    logic sdaPull;
    logic sdaRel;
    logic sdaFromShift;
    logic loadShort;
    logic loadFull;
    logic tmoClear;
    logic loadByte;
    logic shiftOut;
    logic shiftIn;
    logic ackCapture;
    logic errSet;
    logic errClear;
  } strobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic dlyZero;
    logic sclRise;
    logic tmoHit;
    logic bitLast;
  } status_t;

  typedef enum logic [4:0] {
    S_IDLE, S_DLY, S_WHI, S_ENDLOW, S_FIN,
    S_RS_REL, S_RS_B, S_RS_C,
    S_SP_B, S_SP_C, S_SP_D,
    S_WB_A, S_WB_B, S_WB_C, S_WB_D,
    S_WA_A, S_WA_B, S_WA_C, S_WA_D,
    S_RB_A, S_RB_B,
    S_AK_A, S_AK_B
  } state_t;

endpackage

// File: rtl/i2c_bit_dp.sv
module i2c_bit_dp
  import i2c_bit_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [DLY_W-1:0] delayCycles,
  input  logic [TMO_W-1:0] timeoutCycles,
  input  logic [7:0]       wrData,
  input  logic             sclIn,
  input  logic             sdaIn,
  output status_t          stat,
  output logic             sclOut,
  output logic             sdaOut,
  output logic [7:0]       rdData,
  output logic             ackRx,
  output logic             timeoutErr
);

  // release-to-sample latency: output flop plus synchronizer stages
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam logic [TMO_W-1:0] TMO_MAX = '1;
  localparam logic [TMO_W-1:0] SETTLE_CNT = TMO_W'(SETTLE);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclSync, sdaSync;
  logic [DLY_W-1:0]       dlyCnt, shortVal;
  logic [TMO_W-1:0]       tmoCnt;
  logic [7:0]             shiftReg;
  logic [2:0]             bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
    end
  end
  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];

  // half period rounded up
  assign shortVal = (delayCycles >> 1) + DLY_W'(delayCycles[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dlyCnt <= '0;
    else if (strb.loadShort) dlyCnt <= shortVal;
    else if (strb.loadFull)  dlyCnt <= delayCycles;
    else if (dlyCnt != '0)   dlyCnt <= dlyCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tmoCnt <= '0;
    else if (strb.tmoClear)   tmoCnt <= '0;
    else if (tmoCnt != TMO_MAX) tmoCnt <= tmoCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strb.loadByte) begin
      shiftReg <= wrData;
      bitCnt   <= 3'd7;
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[6:0], 1'b0};
      bitCnt   <= bitCnt - 1'b1;
    end else if (strb.shiftIn) begin
      shiftReg <= {shiftReg[6:0], sdaSync};
      bitCnt   <= bitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sclOut <= 1'b1;
    else if (strb.sclPull) sclOut <= 1'b0;
    else if (strb.sclRel)  sclOut <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sdaOut <= 1'b1;
    else if (strb.sdaPull)      sdaOut <= 1'b0;
    else if (strb.sdaRel)       sdaOut <= 1'b1;
    else if (strb.sdaFromShift) sdaOut <= shiftReg[7];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackRx      <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      if (strb.ackCapture) ackRx <= ~sdaSync;
      if (strb.errSet)        timeoutErr <= 1'b1;
      else if (strb.errClear) timeoutErr <= 1'b0;
    end
  end

  assign rdData       = shiftReg;
  assign stat.dlyZero = (dlyCnt == '0);
  assign stat.sclRise = sclSync && (tmoCnt >= SETTLE_CNT);
  assign stat.tmoHit  = (tmoCnt >= timeoutCycles);
  assign stat.bitLast = (bitCnt == 3'd0);

  // R6: clock and data outputs never move on the same edge
  assert_no_joint_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclOut) |-> $stable(sdaOut));

  // R11: an error is raised only after the limit was reached
  assert_err_needs_limit_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $past(stat.tmoHit));

endmodule

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_bit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       cmdAck,
  input  status_t    stat,
  output strobe_t    strb,
  output logic       cmdReady,
  output logic       busy,
  output logic       done
);

  state_t state, nextState, retState, nextRet;
  logic   finish;

  always_comb begin
    strb      = '0;
    nextState = state;
    nextRet   = retState;
    finish    = 1'b0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        strb.errClear = 1'b1;
        case (cmdOp)
          OP_START: begin
            strb.sdaPull = 1'b1; strb.loadShort = 1'b1;
            nextState = S_DLY; nextRet = S_ENDLOW;
          end
          OP_RESTART: begin
            strb.sdaRel = 1'b1; nextState = S_RS_REL;
          end
          OP_STOP: begin
            strb.sdaPull = 1'b1; strb.loadShort = 1'b1;
            nextState = S_DLY; nextRet = S_SP_B;
          end
          OP_WRITE: begin
            strb.loadByte = 1'b1; nextState = S_WB_A;
          end
          OP_READ: begin
            strb.loadByte = 1'b1; strb.sdaRel = 1'b1; strb.loadShort = 1'b1;
            nextState = S_DLY; nextRet = S_RB_A;
          end
          OP_ACK: begin
            strb.sdaPull = cmdAck; strb.sdaRel = ~cmdAck; strb.loadShort = 1'b1;
            nextState = S_DLY; nextRet = S_AK_A;
          end
          default: finish = 1'b1;
        endcase
      end
      S_DLY: if (stat.dlyZero) nextState = retState;
      S_WHI: begin
        if (stat.sclRise) begin
          strb.loadShort = 1'b1; nextState = S_DLY;
        end else if (stat.tmoHit) begin
          strb.errSet = 1'b1; finish = 1'b1;
        end
      end
      S_ENDLOW: begin strb.sclPull = 1'b1; finish = 1'b1; end
      S_FIN:    finish = 1'b1;
      S_RS_REL: begin
        strb.sclRel = 1'b1; strb.tmoClear = 1'b1; nextState = S_WHI; nextRet = S_RS_B;
      end
      S_RS_B: begin strb.loadShort = 1'b1; nextState = S_DLY; nextRet = S_RS_C; end
      S_RS_C: begin
        strb.sdaPull = 1'b1; strb.loadShort = 1'b1; nextState = S_DLY; nextRet = S_ENDLOW;
      end
      S_SP_B: begin
        strb.sclRel = 1'b1; strb.tmoClear = 1'b1; nextState = S_WHI; nextRet = S_SP_C;
      end
      S_SP_C: begin strb.loadShort = 1'b1; nextState = S_DLY; nextRet = S_SP_D; end
      S_SP_D: begin
        strb.sdaRel = 1'b1; strb.loadFull = 1'b1; nextState = S_DLY; nextRet = S_FIN;
      end
      S_WB_A: begin strb.sclPull = 1'b1; nextState = S_WB_B; end
      S_WB_B: begin
        strb.sdaFromShift = 1'b1; strb.loadShort = 1'b1; nextState = S_DLY; nextRet = S_WB_C;
      end
      S_WB_C: begin
        strb.sclRel = 1'b1; strb.tmoClear = 1'b1; nextState = S_WHI; nextRet = S_WB_D;
      end
      S_WB_D: begin
        if (stat.bitLast) nextState = S_WA_A;
        else begin strb.shiftOut = 1'b1; nextState = S_WB_A; end
      end
      S_WA_A: begin
        strb.sclPull = 1'b1; strb.loadShort = 1'b1; nextState = S_DLY; nextRet = S_WA_B;
      end
      S_WA_B: begin
        strb.sdaRel = 1'b1; strb.loadShort = 1'b1; nextState = S_DLY; nextRet = S_WA_C;
      end
      S_WA_C: begin
        strb.sclRel = 1'b1; strb.tmoClear = 1'b1; nextState = S_WHI; nextRet = S_WA_D;
      end
      S_WA_D: begin strb.ackCapture = 1'b1; strb.sclPull = 1'b1; finish = 1'b1; end
      S_RB_A: begin
        strb.sclRel = 1'b1; strb.tmoClear = 1'b1; nextState = S_WHI; nextRet = S_RB_B;
      end
      S_RB_B: begin
        strb.shiftIn = 1'b1; strb.sclPull = 1'b1; strb.loadFull = 1'b1;
        nextState = S_DLY; nextRet = stat.bitLast ? S_FIN : S_RB_A;
      end
      S_AK_A: begin
        strb.sclRel = 1'b1; strb.tmoClear = 1'b1; nextState = S_WHI; nextRet = S_AK_B;
      end
      S_AK_B: begin strb.sclPull = 1'b1; finish = 1'b1; end
      default: nextState = S_IDLE;
    endcase
    if (finish) nextState = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      retState <= S_IDLE;
      done     <= 1'b0;
    end else begin
      state    <= nextState;
      retState <= nextRet;
      done     <= finish;
    end
  end

  assign cmdReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);

  // R2: an accepted command is either running or completing next cycle
  assert_accept_progress_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (busy || done));

  // R2: the completion pulse coincides with the engine being idle
  assert_done_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2: completion is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done || $past(cmdValid));

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [2:0]       cmdOp,
  input  logic             cmdAck,
  input  logic [7:0]       wrData,
  input  logic [DLY_W-1:0] delayCycles,
  input  logic [TMO_W-1:0] timeoutCycles,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rdData,
  output logic             ackRx,
  output logic             timeoutErr,
  output logic             sclOut,
  input  logic             sclIn,
  output logic             sdaOut,
  input  logic             sdaIn
);

  strobe_t strb;
  status_t stat;

  i2c_bit_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAck(cmdAck),
    .stat(stat), .strb(strb), .cmdReady(cmdReady), .busy(busy), .done(done)
  );

  i2c_bit_dp #(.DLY_W(DLY_W), .TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .delayCycles(delayCycles),
    .timeoutCycles(timeoutCycles), .wrData(wrData), .sclIn(sclIn), .sdaIn(sdaIn),
    .stat(stat), .sclOut(sclOut), .sdaOut(sdaOut), .rdData(rdData),
    .ackRx(ackRx), .timeoutErr(timeoutErr)
  );

  // R11: a timeout is only ever reported together with completion
  assert_timeout_with_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> done);

endmodule

// File: tb/sim_i2c_bit_engine.sv
module sim_i2c_bit_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic        cmdAck = 1'b0;
  logic [7:0]  wrData = 8'd0;
  logic [15:0] delayCycles = 16'd10;
  logic [15:0] timeoutCycles = 16'd60;
  logic        cmdReady, busy, done, ackRx, timeoutErr, sclOut, sdaOut;
  logic [7:0]  rdData;

  logic       tgtSclLow = 1'b0;
  int         tgtMode = 0;
  logic [7:0] tgtByte = 8'd0;
  logic       sdaTgt;
  wire        sclLine = sclOut & ~tgtSclLow;
  wire        sdaLine = sdaOut & sdaTgt;

  int tests = 0, fails = 0, cyc = 0;
  int edgeCnt = 0, monCount = 0, startSeen = 0, stopSeen = 0, sdaViol = 0;
  int tSdaFall = 0, tSclFall = 0, tSdaRise = 0;
  logic [31:0] monBits = '0;
  logic dataPhase = 1'b0;
  logic finished = 1'b0;

  i2c_bit_engine u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdAck(cmdAck), .wrData(wrData), .delayCycles(delayCycles),
    .timeoutCycles(timeoutCycles), .busy(busy), .done(done), .rdData(rdData),
    .ackRx(ackRx), .timeoutErr(timeoutErr), .sclOut(sclOut), .sclIn(sclLine),
    .sdaOut(sdaOut), .sdaIn(sdaLine)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // target model: mode 1 acks the ninth clock, mode 2 returns tgtByte
  always_comb begin
    case (tgtMode)
      1:       sdaTgt = !(edgeCnt == 8);
      2:       sdaTgt = (edgeCnt < 8) ? tgtByte[3'(7 - edgeCnt)] : 1'b1;
      default: sdaTgt = 1'b1;
    endcase
  end

  always @(negedge sclLine) begin edgeCnt++; tSclFall = cyc; end
  always @(posedge sclLine) begin monBits = {monBits[30:0], sdaLine}; monCount++; end
  always @(negedge sdaLine) if (sclLine) begin startSeen++; tSdaFall = cyc; end
  always @(posedge sdaLine) if (sclLine) begin stopSeen++; tSdaRise = cyc; end
  always @(sdaLine) if (sclLine && dataPhase) sdaViol++;

  task automatic check(input string req, input int actual, input int expected, input string what);
    tests++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic checkMin(input string req, input int actual, input int lowest, input string what);
    tests++;
    if (actual < lowest) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, actual, lowest);
    end
  endtask

  task automatic issueCmd(input logic [2:0] op, input logic [7:0] data, input logic ack);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; wrData = data; cmdAck = ack;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [7:0] data, input logic ack);
    issueCmd(op, data, ack);
    waitDone();
  endtask

  task automatic t_reset();
    check("R1", sclOut, 1, "scl after reset");
    check("R1", sdaOut, 1, "sda after reset");
    check("R1", {busy, cmdReady, done}, 3'b010, "busy/ready/done after reset");
  endtask

  task automatic t_start(input int shortExp);
    int s0;
    s0 = startSeen;
    issueCmd(3'd0, 8'h00, 1'b0);
    check("R2", {busy, cmdReady}, 2'b10, "busy/ready while running");
    waitDone();
    check("R2", busy, 0, "busy with done");
    check("R3", startSeen - s0, 1, "start edges");
    checkMin("R3", tSclFall - tSdaFall, shortExp, "sda-to-scl gap");
    check("R3", {sclOut, sdaOut}, 2'b00, "lines after start");
  endtask

  task automatic t_write(input logic [7:0] data, input logic tgtAck);
    dataPhase = 1'b1; tgtMode = tgtAck ? 1 : 0; edgeCnt = 0;
    runCmd(3'd3, data, 1'b0);
    check("R6", monBits[8:1], data, "bits on bus");
    check("R7", ackRx, tgtAck, "ack result");
    check("R7", monBits[0], !tgtAck, "ninth bit level");
    tgtMode = 0;
  endtask

  task automatic t_read(input logic [7:0] data, input logic ack);
    dataPhase = 1'b1; tgtByte = data; tgtMode = 2; edgeCnt = 0;
    runCmd(3'd4, 8'h00, 1'b0);
    check("R8", rdData, data, "read byte");
    check("R8", monBits[7:0], data, "bus bits during read");
    runCmd(3'd5, 8'h00, ack);
    check("R9", monBits[0], !ack, "master ack bit");
    tgtMode = 0;
  endtask

  task automatic t_restart();
    int s0, p0;
    dataPhase = 1'b0; s0 = startSeen; p0 = stopSeen;
    runCmd(3'd1, 8'h00, 1'b0);
    check("R4", startSeen - s0, 1, "repeated start edge");
    check("R4", stopSeen - p0, 0, "no stop during restart");
    check("R4", sclOut, 0, "scl low after restart");
  endtask

  task automatic t_stop(input int fullExp);
    int p0;
    dataPhase = 1'b0; p0 = stopSeen;
    runCmd(3'd2, 8'h00, 1'b0);
    check("R5", stopSeen - p0, 1, "stop edge");
    checkMin("R5", cyc - tSdaRise, fullExp, "bus free time");
    check("R5", {sclLine, sdaLine}, 2'b11, "lines after stop");
  endtask

  task automatic t_stretch();
    int m0;
    dataPhase = 1'b1; tgtMode = 1; edgeCnt = 0; tgtSclLow = 1'b1;
    m0 = monCount;
    issueCmd(3'd3, 8'hC3, 1'b0);
    repeat (40) @(negedge clk);
    check("R10", {busy, done}, 2'b10, "held while stretched");
    check("R10", monCount - m0, 0, "no clock while stretched");
    tgtSclLow = 1'b0;
    waitDone();
    check("R10", monBits[8:1], 8'hC3, "bits after stretch");
    check("R10", timeoutErr, 0, "no error after stretch");
    tgtMode = 0;
  endtask

  task automatic t_timeout();
    int c0;
    dataPhase = 1'b0; tgtSclLow = 1'b1;
    c0 = cyc;
    runCmd(3'd4, 8'h00, 1'b0);
    check("R11", timeoutErr, 1, "timeout flagged");
    checkMin("R11", cyc - c0, 60, "cycles before timeout");
    tgtSclLow = 1'b0;
    runCmd(3'd2, 8'h00, 1'b0);
    check("R11", timeoutErr, 0, "error cleared by next command");
  endtask

  task automatic t_noop();
    logic s0, d0;
    s0 = sclOut; d0 = sdaOut;
    issueCmd(3'd6, 8'hFF, 1'b1);
    check("R2", {done, busy}, 2'b10, "undefined opcode completes next cycle");
    @(negedge clk);
    check("R2", {sclOut, sdaOut}, {s0, d0}, "lines unchanged by undefined opcode");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_start(5);
    t_write(8'hA5, 1'b1);
    t_write(8'h3C, 1'b0);
    t_restart();
    dataPhase = 1'b1;
    t_read(8'h96, 1'b1);
    t_read(8'h5A, 1'b0);
    t_stop(10);
    t_start(5);
    t_stretch();
    t_timeout();
    t_noop();
    delayCycles = 16'd3;
    t_start(2);
    t_write(8'h81, 1'b1);
    t_stop(3);
    check("R6", sdaViol, 0, "sda changes during scl high in data phases");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule